// File: doc/BRIEF.md
# Frame-Committing Circular Byte Buffer

This block is a circular byte store with a register-style access port, meant for staging radio packets between a packet engine and software. Besides the usual read and write positions it keeps a frame-start mark on each side. On the write side, a partly written frame can be thrown away by winding the write position back to its mark. On the read side, storage is released only when the read-side mark moves. The mark moves automatically per byte or in one step on an explicit commit, so a whole frame is released or kept as a unit.

All four positions and a threshold can be read and written over a small register bus. The fill length and a threshold flag report how much of the store is taken. Command strobes commit either side or discard the pending write frame.

Top module: `framed_fifo`

## Requirements
- R1: After reset all four positions, the threshold and `bus_rdata` are zero, and `thr_flag` is 1.
- R2: A bus write to address 0 stores the byte at the write position and advances it by one. When the write position plus one equals the read-side mark, the buffer is full and the write changes neither memory nor any position.
- R3: A bus read of address 0 returns, on `bus_rdata` one cycle later, the byte at the read position and advances it by one. When the read position equals the write-side mark, the read returns 0x00 and the read position is unchanged.
- R4: With `cfg_auto_rd` high, every successful data read also advances the read-side mark by one.
- R5: With `cfg_auto_wr` high, every successful data write also advances the write-side mark by one.
- R6: `cmd_commit_rd` copies the read position into the read-side mark. `cmd_commit_wr` copies the write position into the write-side mark.
- R7: `cmd_discard` loads the write position from the write-side mark. It wins over `cmd_commit_wr` in the same cycle, which then leaves the mark unchanged. A data write in the same cycle is dropped.
- R8: The register map is: 0 data, 1 write position, 2 read position, 3 write-side mark, 4 read-side mark, 5 length, 6 threshold, 7 reads as zero. Positions, marks and threshold take the low 7 bits of a write. They read back with bit 7 zero, and non-data reads have no side effect.
- R9: Address 5 reads the length (write position − read-side mark) mod 128. Writes to it are ignored.
- R10: `thr_flag` is 1 exactly when the length is greater than or equal to the threshold.
- R11: All positions and marks wrap from 127 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| cmd_commit_rd | input | 1 | Move read-side mark to read position |
| cmd_commit_wr | input | 1 | Move write-side mark to write position |
| cmd_discard | input | 1 | Wind write position back to write-side mark |
| cfg_auto_rd | input | 1 | Advance read-side mark on each read |
| cfg_auto_wr | input | 1 | Advance write-side mark on each write |
| thr_flag | output | 1 | Length ≥ threshold |

## Verification
The properties assume the bus never asserts read and write enables in the same cycle, and one property checks that assumption directly. The bench drives every access as a single-cycle pulse from a task that raises one enable at a time. The frame-level checks condition on the absence of a competing register write to the same position. The stimulus never combines a direct position write with a strobe, so every bus write, commit and discard happens in its own cycle.

// File: rtl/framed_fifo.sv
module framed_fifo #(
  parameter int PW     = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmd_commit_rd,
  input  logic              cmd_commit_wr,
  input  logic              cmd_discard,
  input  logic              cfg_auto_rd,
  input  logic              cfg_auto_wr,
  output logic              thr_flag
);
  localparam int DEPTH = 1 << PW;
  localparam int PAD   = DATA_W - PW;
  localparam logic [2:0] A_DATA = 3'd0, A_WP = 3'd1, A_RP = 3'd2,
                         A_SWP = 3'd3, A_SRP = 3'd4, A_LEN = 3'd5, A_THR = 3'd6;

  logic [PW-1:0] wp, rp, swp, srp, thr;
  logic [DATA_W-1:0] mem [DEPTH];

  logic [PW-1:0] wp_n, rp_n, swp_n, srp_n, level;
  logic full, empty, push, pop;

  assign wp_n  = wp + 1'b1;
  assign rp_n  = rp + 1'b1;
  assign swp_n = swp + 1'b1;
  assign srp_n = srp + 1'b1;
  assign level = wp - srp;
  assign full  = (wp_n == srp);
  assign empty = (rp == swp);
  assign push  = bus_wr && bus_addr == A_DATA && !full && !cmd_discard;
  assign pop   = bus_rd && bus_addr == A_DATA && !empty;
  assign thr_flag = (level >= thr);

  wire wr_wp  = bus_wr && bus_addr == A_WP;
  wire wr_rp  = bus_wr && bus_addr == A_RP;
  wire wr_swp = bus_wr && bus_addr == A_SWP;
  wire wr_srp = bus_wr && bus_addr == A_SRP;
  wire wr_thr = bus_wr && bus_addr == A_THR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wp <= '0;
    else if (wr_wp)           wp <= bus_wdata[PW-1:0];
    else if (cmd_discard)     wp <= swp;
    else if (push)            wp <= wp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              swp <= '0;
    else if (wr_swp)                         swp <= bus_wdata[PW-1:0];
    else if (cmd_commit_wr && !cmd_discard)  swp <= wp;
    else if (push && cfg_auto_wr)            swp <= swp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rp <= '0;
    else if (wr_rp)  rp <= bus_wdata[PW-1:0];
    else if (pop)    rp <= rp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  srp <= '0;
    else if (wr_srp)             srp <= bus_wdata[PW-1:0];
    else if (cmd_commit_rd)      srp <= rp;
    else if (pop && cfg_auto_rd) srp <= srp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       thr <= '0;
    else if (wr_thr)  thr <= bus_wdata[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata <= empty ? '0 : mem[rp];
        A_WP:    bus_rdata <= {{PAD{1'b0}}, wp};
        A_RP:    bus_rdata <= {{PAD{1'b0}}, rp};
        A_SWP:   bus_rdata <= {{PAD{1'b0}}, swp};
        A_SRP:   bus_rdata <= {{PAD{1'b0}}, srp};
        A_LEN:   bus_rdata <= {{PAD{1'b0}}, level};
        A_THR:   bus_rdata <= {{PAD{1'b0}}, thr};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/framed_fifo_chk.sv
module framed_fifo_chk #(
  parameter int PW     = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cmd_commit_rd,
  input logic              cmd_commit_wr,
  input logic              cmd_discard,
  input logic              cfg_auto_rd,
  input logic              cfg_auto_wr,
  input logic [PW-1:0]     wp,
  input logic [PW-1:0]     rp,
  input logic [PW-1:0]     swp,
  input logic [PW-1:0]     srp
);
  logic [PW-1:0] c_wp1, c_swp1, c_srp1;
  assign c_wp1  = wp + 1'b1;
  assign c_swp1 = swp + 1'b1;
  assign c_srp1 = srp + 1'b1;

  assert_bus_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && c_wp1 == srp && !cmd_discard) |=> $stable(wp));

  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && rp == swp) |=> (bus_rdata == '0 && $stable(rp)));

  assert_auto_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && rp != swp && cfg_auto_rd && !cmd_commit_rd)
    |=> srp == $past(c_srp1));

  assert_auto_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && c_wp1 != srp && !cmd_discard && cfg_auto_wr && !cmd_commit_wr)
    |=> swp == $past(c_swp1));

  assert_commit_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit_rd && !(bus_wr && bus_addr == 3'd4)) |=> srp == $past(rp));

  assert_discard_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_discard && !(bus_wr && bus_addr == 3'd1)) |=> wp == $past(swp));

  assert_discard_keeps_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_discard && !(bus_wr && bus_addr == 3'd3)) |=> $stable(swp));
endmodule

bind framed_fifo framed_fifo_chk #(.PW(PW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .cmd_commit_rd(cmd_commit_rd), .cmd_commit_wr(cmd_commit_wr),
  .cmd_discard(cmd_discard), .cfg_auto_rd(cfg_auto_rd), .cfg_auto_wr(cfg_auto_wr),
  .wp(wp), .rp(rp), .swp(swp), .srp(srp)
);

// File: tb/framed_fifo_test.sv
module framed_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cmd_commit_rd = 1'b0, cmd_commit_wr = 1'b0, cmd_discard = 1'b0;
  logic cfg_auto_rd = 1'b0, cfg_auto_wr = 1'b0;
  logic thr_flag;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  framed_fifo uut (.*);

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_ST = 2'd2;
  localparam int NV = 32;
  // {kind, addr, data, expected, requirement number}
  localparam logic [24:0] VEC [NV] = '{
    {K_RD, 3'd1, 8'h00, 8'h00, 4'd1},   // R1 write position zero
    {K_RD, 3'd6, 8'h00, 8'h00, 4'd1},   // R1 threshold zero
    {K_WR, 3'd0, 8'hA1, 8'h00, 4'd2},
    {K_WR, 3'd0, 8'hB2, 8'h00, 4'd2},
    {K_RD, 3'd1, 8'h00, 8'h02, 4'd2},   // R2 two writes advance
    {K_RD, 3'd0, 8'h00, 8'h00, 4'd3},   // R3 nothing committed -> 0x00
    {K_RD, 3'd2, 8'h00, 8'h00, 4'd3},   // R3 read position held
    {K_ST, 3'd0, 8'h02, 8'h00, 4'd6},
    {K_RD, 3'd3, 8'h00, 8'h02, 4'd6},   // R6 write mark committed
    {K_RD, 3'd0, 8'h00, 8'hA1, 4'd3},
    {K_RD, 3'd0, 8'h00, 8'hB2, 4'd3},
    {K_RD, 3'd0, 8'h00, 8'h00, 4'd3},
    {K_RD, 3'd5, 8'h00, 8'h02, 4'd9},   // R9 length
    {K_ST, 3'd0, 8'h01, 8'h00, 4'd6},
    {K_RD, 3'd4, 8'h00, 8'h02, 4'd6},   // R6 read mark committed
    {K_RD, 3'd5, 8'h00, 8'h00, 4'd9},
    {K_WR, 3'd0, 8'hC3, 8'h00, 4'd7},
    {K_ST, 3'd0, 8'h04, 8'h00, 4'd7},
    {K_RD, 3'd1, 8'h00, 8'h02, 4'd7},   // R7 discard rewinds
    {K_WR, 3'd0, 8'hD4, 8'h00, 4'd7},
    {K_ST, 3'd0, 8'h06, 8'h00, 4'd7},
    {K_RD, 3'd1, 8'h00, 8'h02, 4'd7},   // R7 discard wins
    {K_RD, 3'd3, 8'h00, 8'h02, 4'd7},   // R7 mark untouched
    {K_WR, 3'd6, 8'h05, 8'h00, 4'd8},
    {K_RD, 3'd6, 8'h00, 8'h05, 4'd8},   // R8 threshold readback
    {K_WR, 3'd5, 8'h33, 8'h00, 4'd9},
    {K_RD, 3'd5, 8'h00, 8'h00, 4'd9},   // R9 length write ignored
    {K_WR, 3'd2, 8'hFF, 8'h00, 4'd8},
    {K_RD, 3'd2, 8'h00, 8'h7F, 4'd8},   // R8 top bit dropped
    {K_WR, 3'd2, 8'h02, 8'h00, 4'd8},
    {K_RD, 3'd2, 8'h00, 8'h02, 4'd8},
    {K_RD, 3'd7, 8'h00, 8'h00, 4'd8}    // R8 unused address
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic strobe(input logic [2:0] s);
    {cmd_discard, cmd_commit_wr, cmd_commit_rd} = s;
    @(negedge clk);
    {cmd_discard, cmd_commit_wr, cmd_commit_rd} = 3'b000;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 thr_flag", {7'd0, thr_flag}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] e;
      e = VEC[i];
      case (e[24:23])
        K_WR: wr(e[22:20], e[19:12]);
        K_RD: begin
          rd(e[22:20], v);
          check($sformatf("R%0d vector %0d", e[3:0], i), v, e[11:4]);
        end
        default: strobe(e[14:12]);
      endcase
    end
    check("R10 flag low, length 0 below 5", {7'd0, thr_flag}, 8'h00);

    // R11 wrap with auto marks on both sides (R4, R5)
    cfg_auto_rd = 1'b1; cfg_auto_wr = 1'b1;
    for (int a = 1; a <= 4; a++) wr(3'(a), 8'h7E);
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    rd(3'd1, v); check("R11 write position wraps", v, 8'h01);
    rd(3'd3, v); check("R5 write mark follows", v, 8'h01);
    check("R10 flag low, length 3", {7'd0, thr_flag}, 8'h00);
    wr(3'd0, 8'h44); wr(3'd0, 8'h55);
    check("R10 flag high, length 5", {7'd0, thr_flag}, 8'h01);
    for (int k = 1; k <= 5; k++) begin
      rd(3'd0, v);
      check("R3 data across wrap", v, 8'(k * 8'h11));
    end
    rd(3'd4, v); check("R4 read mark follows", v, 8'h03);
    rd(3'd0, v); check("R3 drained read", v, 8'h00);

    // R2 full buffer
    cfg_auto_rd = 1'b0;
    for (int a = 1; a <= 4; a++) wr(3'(a), 8'h00);
    for (int k = 0; k < 127; k++) wr(3'd0, 8'(k) ^ 8'h5A);
    rd(3'd5, v); check("R9 length full", v, 8'h7F);
    wr(3'd0, 8'hEE);
    rd(3'd1, v); check("R2 write when full ignored", v, 8'h7F);
    rd(3'd0, v); check("R2 first byte intact", v, 8'h5A);
    wr(3'd0, 8'hEE);
    rd(3'd1, v); check("R2 still full without release", v, 8'h7F);
    rd(3'd4, v); check("R4 mark held with auto off", v, 8'h00);
    strobe(3'b001);
    wr(3'd0, 8'hEE);
    rd(3'd1, v); check("R11 write after release wraps", v, 8'h00);
    rd(3'd5, v); check("R9 length modulo", v, 8'h7F);
    rd(3'd0, v); check("R2 second byte", v, 8'h5B);

    finish_run();
  end
endmodule